// File: doc/BRIEF.md
# Serial Transmit Channel with Clear-to-Send Gating and Automatic Request-to-Send Release

This block is the transmit half of an asynchronous serial port. A byte written while the channel is ready goes into a one-entry holding register. From there it moves into the shift register and leaves on the line as a frame: one start bit, 5 to 8 data bits sent LSB first, an optional parity bit, and a stop period. The stop period is set in sixteenth-of-a-bit steps. A tick enable drives all timing. In the normal mode there are 16 ticks per bit. In the 1x mode each tick is one whole bit.

Flow control works on both handshake lines. The active-low clear-to-send input can hold back each new character. It is looked at only when a character is about to start. The active-low request-to-send output is the inverse of a bit that software sets and clears with separate commands. With automatic release on, a disable command does not cut off data already accepted. The channel keeps sending until the holding and shift registers are empty. One bit time after the last stop period ends, it releases request-to-send and turns the transmitter off.

Top module: `uart_tx_fc`

## Requirements
- R1: After reset, txd_o and rts_no are high, and tx_rdy_o and tx_emt_o are low.
- R2: After tx_en_i, tx_rdy_o and tx_emt_o are both high (underrun). A write is accepted only while tx_rdy_o is high. A write made while a byte is already held is ignored. tx_rdy_o falls once a byte is held.
- R3: A frame starts on a tick. The start bit is low for 16 ticks. Then come the data bits, LSB first, 16 ticks each. char_len_i values 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits.
- R4: With par_en_i high, a parity bit of 16 ticks follows the data. With par_odd_i=0 it makes the count of ones in data plus parity even. With par_odd_i=1 it makes that count odd.
- R5: For 6, 7 or 8 data bits in 16x mode, the stop period is held high for 9+c ticks when stop_sel_i value c is 0 to 7, and for 17+c ticks when c is 8 to 15.
- R6: For 5 data bits in 16x mode, the stop period is 17+c ticks for every stop_sel_i value c.
- R7: With x1_i high, every bit lasts one tick. The stop period is 1 tick when stop_sel_i[3]=0 and 2 ticks when stop_sel_i[3]=1.
- R8: With cts_en_i high, no character starts while cts_ni is high, and txd_o stays high. The character starts on the first tick with cts_ni low. With cts_en_i low, cts_ni has no effect.
- R9: A change of cts_ni while a character is being sent does not alter that character.
- R10: After tx_dis_i, tx_rdy_o goes low. The character being shifted and any held character are still sent in full. Once both are gone, the transmitter is off (tx_rdy_o and tx_emt_o low, txd_o high).
- R11: With auto_rts_i high and a disable pending, rts_no goes high exactly 16 ticks after the last stop period ends. With auto_rts_i low, rts_no does not change on a disable.
- R12: rts_no is the inverse of a bit that rts_set_i sets and rts_clr_i clears. If both arrive in the same cycle, the set wins.
- R13: If a byte is held when a stop period ends, the next start bit begins on the very next tick, with no idle gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Baud tick enable (1/16 bit, or one bit in 1x mode) |
| x1_i | input | 1 | 1x clock mode select |
| char_len_i | input | 2 | Data bits minus 5 |
| par_en_i | input | 1 | Parity bit enable |
| par_odd_i | input | 1 | Odd parity select |
| stop_sel_i | input | 4 | Stop length code |
| cts_en_i | input | 1 | Clear-to-send gating enable |
| auto_rts_i | input | 1 | Automatic request-to-send release enable |
| wr_i | input | 1 | Write strobe for wdata_i |
| wdata_i | input | 8 | Byte to send |
| tx_en_i | input | 1 | Enable command pulse |
| tx_dis_i | input | 1 | Disable command pulse |
| rts_set_i | input | 1 | Set request-to-send bit |
| rts_clr_i | input | 1 | Clear request-to-send bit |
| cts_ni | input | 1 | Clear-to-send, active low |
| txd_o | output | 1 | Serial data out, high when idle |
| rts_no | output | 1 | Request-to-send, active low |
| tx_rdy_o | output | 1 | Holding register can take a byte |
| tx_emt_o | output | 1 | Enabled, with holding and shift registers empty |

## Verification
Some rules are checked by assertions on every cycle. A blocked clear-to-send keeps the line at mark. A start bit follows every load. Underrun implies ready unless a disable is pending. A held byte stays put until it is loaded. A disabled channel keeps the line high. The automatic release drops the request-to-send bit. Other behaviour can only be shown by the bench's scenarios, which compare the whole frame tick by tick: the exact tick counts of every stop code, the bit order, parity and back-to-back spacing, the tick at which request-to-send releases, and the fact that a mid-frame clear-to-send change leaves the character intact.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_DRAIN
  } tx_st_e;

  // Stop period in ticks; short codes give ovs/2+1+c, long codes ovs+1+c.
  function automatic logic [5:0] stop_ticks(input int ovs, input logic x1,
                                            input logic [1:0] clen,
                                            input logic [3:0] code);
    if (x1) return code[3] ? 6'd2 : 6'd1;
    if (clen == 2'd0 || code[3]) return 6'(ovs + 1) + {2'b00, code};
    return 6'(ovs / 2 + 1) + {2'b00, code};
  endfunction

endpackage

// File: rtl/tx_ctrl.sv
module tx_ctrl #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          en_cmd_i,
  input  logic          dis_cmd_i,
  input  logic          rts_set_i,
  input  logic          rts_clr_i,
  input  logic          auto_rts_i,
  input  logic          load_i,
  input  logic          busy_i,
  input  logic          done_i,
  output logic          hold_full_o,
  output logic [DW-1:0] hold_data_o,
  output logic          dis_pend_o,
  output logic          en_o,
  output logic          rts_o,
  output logic          tx_rdy_o,
  output logic          tx_emt_o
);

  logic          en_q, dis_pend_q, hold_full_q, rts_q;
  logic [DW-1:0] hold_q;
  logic          empty, fin;

  assign empty    = ~hold_full_q & ~busy_i;
  assign tx_rdy_o = en_q & ~dis_pend_q & ~hold_full_q;
  assign tx_emt_o = en_q & empty;
  // pending disable completes when the line is drained (drain step signalled by done_i)
  assign fin      = dis_pend_q & (done_i | empty);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q        <= 1'b0;
      dis_pend_q  <= 1'b0;
      hold_full_q <= 1'b0;
      hold_q      <= '0;
      rts_q       <= 1'b0;
    end else begin
      if (load_i) hold_full_q <= 1'b0;
      else if (wr_i && tx_rdy_o) begin
        hold_full_q <= 1'b1;
        hold_q      <= wdata_i;
      end

      if (en_cmd_i) begin
        en_q       <= 1'b1;
        dis_pend_q <= 1'b0;
      end else if (fin) begin
        en_q       <= 1'b0;
        dis_pend_q <= 1'b0;
      end else if (dis_cmd_i && en_q) begin
        dis_pend_q <= 1'b1;
      end

      if (rts_set_i)      rts_q <= 1'b1;
      else if (rts_clr_i) rts_q <= 1'b0;
      else if (fin && auto_rts_i && !en_cmd_i) rts_q <= 1'b0;
    end
  end

  assign hold_full_o = hold_full_q;
  assign hold_data_o = hold_q;
  assign dis_pend_o  = dis_pend_q;
  assign en_o        = en_q;
  assign rts_o       = rts_q;

  AST_UNDERRUN_RDY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_emt_o && !dis_pend_q) |-> tx_rdy_o); // R2
  AST_HOLD_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_full_q && !load_i) |=> (hold_full_q && $stable(hold_q))); // R10
  AST_RTS_AUTO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && dis_pend_q && auto_rts_i && !rts_set_i && !en_cmd_i) |=> !rts_q); // R11

endmodule

// File: rtl/tx_shifter.sv
module tx_shifter
  import uart_tx_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OVS = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          x1_i,
  input  logic [1:0]    clen_i,
  input  logic          par_en_i,
  input  logic          par_odd_i,
  input  logic [3:0]    stop_sel_i,
  input  logic          cts_en_i,
  input  logic          cts_ni,
  input  logic          hold_full_i,
  input  logic [DW-1:0] hold_data_i,
  input  logic          drain_req_i,
  output logic          load_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          txd_o
);

  localparam int CW = 6;
  localparam int BW = $clog2(DW);

  tx_st_e        st_q;
  logic [CW-1:0] cnt_q, bit_last, stop_len;
  logic [BW-1:0] bitn_q, last_bit;
  logic [DW-1:0] sh_q, mask;
  logic          par_q, txd_q, go, cnt_end, stop_end;

  assign bit_last = x1_i ? '0 : CW'(OVS - 1);
  assign stop_len = stop_ticks(OVS, x1_i, clen_i, stop_sel_i);
  assign last_bit = BW'(4) + BW'(clen_i);
  assign mask     = {DW{1'b1}} >> (2'd3 - clen_i);
  assign go       = hold_full_i & (~cts_en_i | ~cts_ni); // CTS sampled only here
  assign cnt_end  = (cnt_q == '0);
  assign stop_end = tick_i && st_q == ST_STOP && cnt_end;
  assign load_o   = tick_i && go && (st_q == ST_IDLE || (st_q == ST_STOP && cnt_end));
  assign busy_o   = (st_q != ST_IDLE);
  assign done_o   = (stop_end && !hold_full_i && !drain_req_i) ||
                    (tick_i && st_q == ST_DRAIN && cnt_end);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      bitn_q <= '0;
      sh_q   <= '0;
      par_q  <= 1'b0;
      txd_q  <= 1'b1;
    end else if (load_o) begin
      st_q  <= ST_START;
      cnt_q <= bit_last;
      sh_q  <= hold_data_i;
      par_q <= par_odd_i ^ (^(hold_data_i & mask));
      txd_q <= 1'b0;
    end else if (tick_i) begin
      if (!cnt_end) cnt_q <= cnt_q - 1'b1;
      else begin
        unique case (st_q)
          ST_START: begin
            st_q   <= ST_DATA;
            cnt_q  <= bit_last;
            bitn_q <= '0;
            txd_q  <= sh_q[0];
          end
          ST_DATA: begin
            if (bitn_q == last_bit) begin
              if (par_en_i) begin
                st_q  <= ST_PAR;
                cnt_q <= bit_last;
                txd_q <= par_q;
              end else begin
                st_q  <= ST_STOP;
                cnt_q <= stop_len - 1'b1;
                txd_q <= 1'b1;
              end
            end else begin
              sh_q   <= {1'b0, sh_q[DW-1:1]};
              txd_q  <= sh_q[1];
              bitn_q <= bitn_q + 1'b1;
              cnt_q  <= bit_last;
            end
          end
          ST_PAR: begin
            st_q  <= ST_STOP;
            cnt_q <= stop_len - 1'b1;
            txd_q <= 1'b1;
          end
          ST_STOP: begin
            if (drain_req_i && !hold_full_i) begin
              st_q  <= ST_DRAIN;
              cnt_q <= bit_last;
            end else st_q <= ST_IDLE;
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign txd_o = txd_q;

  AST_CTS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && cts_en_i && cts_ni) |=> txd_o); // R8
  AST_START_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> (!txd_o && st_q == ST_START)); // R3
  AST_IDLE_MARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE || st_q == ST_DRAIN) |-> txd_o); // R3

endmodule

// File: rtl/uart_tx_fc.sv
module uart_tx_fc #(
  parameter int DW  = 8,
  parameter int OVS = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          x1_i,
  input  logic [1:0]    char_len_i,
  input  logic          par_en_i,
  input  logic          par_odd_i,
  input  logic [3:0]    stop_sel_i,
  input  logic          cts_en_i,
  input  logic          auto_rts_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          tx_en_i,
  input  logic          tx_dis_i,
  input  logic          rts_set_i,
  input  logic          rts_clr_i,
  input  logic          cts_ni,
  output logic          txd_o,
  output logic          rts_no,
  output logic          tx_rdy_o,
  output logic          tx_emt_o
);

  logic          hold_full, dis_pend, en, rts, load, busy, done;
  logic [DW-1:0] hold_data;

  tx_ctrl #(.DW(DW)) u_ctrl (
    .clk_i, .rst_ni, .wr_i, .wdata_i,
    .en_cmd_i   (tx_en_i),
    .dis_cmd_i  (tx_dis_i),
    .rts_set_i, .rts_clr_i, .auto_rts_i,
    .load_i     (load),
    .busy_i     (busy),
    .done_i     (done),
    .hold_full_o(hold_full),
    .hold_data_o(hold_data),
    .dis_pend_o (dis_pend),
    .en_o       (en),
    .rts_o      (rts),
    .tx_rdy_o, .tx_emt_o
  );

  tx_shifter #(.DW(DW), .OVS(OVS)) u_shift (
    .clk_i, .rst_ni, .tick_i, .x1_i,
    .clen_i     (char_len_i),
    .par_en_i, .par_odd_i, .stop_sel_i, .cts_en_i, .cts_ni,
    .hold_full_i(hold_full),
    .hold_data_i(hold_data),
    .drain_req_i(dis_pend & auto_rts_i),
    .load_o     (load),
    .busy_o     (busy),
    .done_o     (done),
    .txd_o
  );

  assign rts_no = ~rts;

  AST_OFF_MARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |-> txd_o); // R10

endmodule

// File: tb/uart_tx_fc_tb.sv
module uart_tx_fc_tb;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 0, x1_i = 0, par_en_i = 0, par_odd_i = 0;
  logic [1:0] char_len_i = 0;
  logic [3:0] stop_sel_i = 0;
  logic       cts_en_i = 0, auto_rts_i = 0, wr_i = 0;
  logic [7:0] wdata_i = 0;
  logic       tx_en_i = 0, tx_dis_i = 0, rts_set_i = 0, rts_clr_i = 0, cts_ni = 1;
  logic       txd_o, rts_no, tx_rdy_o, tx_emt_o;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  uart_tx_fc u_dut (.*, .clk_i(clk));

  // vector: [16] x1, [15:14] len code, [13] parity en, [12] odd, [11:8] stop code, [7:0] data
  localparam int NV = 9;
  localparam logic [16:0] VEC [NV] = '{
    {1'b0, 2'd3, 1'b0, 1'b0, 4'd0,  8'hA5},
    {1'b0, 2'd3, 1'b1, 1'b0, 4'd7,  8'h3C},
    {1'b0, 2'd2, 1'b1, 1'b1, 4'd8,  8'h55},
    {1'b0, 2'd1, 1'b0, 1'b0, 4'd15, 8'h2B},
    {1'b0, 2'd0, 1'b0, 1'b0, 4'd0,  8'h13},
    {1'b0, 2'd0, 1'b1, 1'b1, 4'd15, 8'h0E},
    {1'b1, 2'd3, 1'b1, 1'b0, 4'd8,  8'h96},
    {1'b1, 2'd2, 1'b0, 1'b0, 4'd3,  8'h71},
    {1'b0, 2'd3, 1'b0, 1'b0, 4'd4,  8'hE1}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int stop_t(input logic [16:0] v);
    if (v[16]) return v[11] ? 2 : 1;
    if (v[15:14] == 2'd0 || v[11]) return 17 + int'(v[11:8]);
    return 9 + int'(v[11:8]);
  endfunction

  function automatic int frame_t(input logic [16:0] v);
    int bt = v[16] ? 1 : 16;
    return bt * (1 + 5 + int'(v[15:14]) + int'(v[13])) + stop_t(v);
  endfunction

  function automatic logic exp_bit(input logic [16:0] v, input logic [7:0] b1,
                                   input bit two, input int i);
    int bt = v[16] ? 1 : 16;
    int n  = 5 + int'(v[15:14]);
    int f  = frame_t(v);
    int j, k;
    logic [7:0] d;
    logic x;
    if (i >= (two ? 2 * f : f)) return 1'b1;
    d = (i < f) ? v[7:0] : b1;
    j = i % f;
    if (j < bt) return 1'b0;
    k = j / bt - 1;
    if (k < n) return d[k];
    if (v[13] && k == n) begin
      x = v[12];
      for (int q = 0; q < n; q++) x ^= d[q];
      return x;
    end
    return 1'b1;
  endfunction

  task automatic do_tick(output logic s);
    @(negedge clk) tick_i = 1'b1;
    @(negedge clk) tick_i = 1'b0;
    s = txd_o;
  endtask

  task automatic wr_byte(input logic [7:0] b);
    @(negedge clk) begin wr_i = 1'b1; wdata_i = b; end
    @(negedge clk) wr_i = 1'b0;
  endtask

  // 0 enable, 1 disable, 2 rts set, 3 rts clear, 4 set+clear
  task automatic cmd(input int which);
    @(negedge clk);
    tx_en_i   = (which == 0);
    tx_dis_i  = (which == 1);
    rts_set_i = (which == 2 || which == 4);
    rts_clr_i = (which == 3 || which == 4);
    @(negedge clk);
    {tx_en_i, tx_dis_i, rts_set_i, rts_clr_i} = '0;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    {tick_i, x1_i, par_en_i, par_odd_i, cts_en_i, auto_rts_i, wr_i} = '0;
    {tx_en_i, tx_dis_i, rts_set_i, rts_clr_i} = '0;
    char_len_i = 0; stop_sel_i = 0; cts_ni = 1'b1;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic set_mode(input logic [16:0] v);
    x1_i = v[16]; char_len_i = v[15:14]; par_en_i = v[13];
    par_odd_i = v[12]; stop_sel_i = v[11:8];
  endtask

  // First tick starts the frame held from v[7:0]; optional second byte b1.
  task automatic run_frames(input logic [16:0] v, input logic [7:0] b1, input bit two,
                            input int flip_at, input string req);
    int total = (two ? 2 * frame_t(v) : frame_t(v)) + 4;
    int bad = -1;
    logic s, e, bad_s;
    for (int i = 0; i < total; i++) begin
      do_tick(s);
      e = exp_bit(v, b1, two, i);
      if (s !== e && bad < 0) begin bad = i; bad_s = s; end
      if (i == 0 && two) wr_byte(b1);
      if (i == flip_at) cts_ni = 1'b1;
    end
    if (bad >= 0) $display("FAIL %s txd mismatch at tick %0d", req, bad);
    chk(bad < 0, req, (bad < 0) ? 0 : int'(bad_s), (bad < 0) ? 0 : int'(exp_bit(v, b1, two, bad)));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic s;
    int bad;
    logic [16:0] v;
    string tag;

    // R1 reset state
    do_reset();
    chk(txd_o === 1 && rts_no === 1 && tx_rdy_o === 0 && tx_emt_o === 0, "R1 reset outputs",
        {txd_o, rts_no, tx_rdy_o, tx_emt_o}, 4'b1100);

    // R12 rts bit commands
    cmd(2); chk(rts_no === 1'b0, "R12 set", rts_no, 0);
    cmd(3); chk(rts_no === 1'b1, "R12 clear", rts_no, 1);
    cmd(4); chk(rts_no === 1'b0, "R12 set wins", rts_no, 0);

    // Vector walk: R3/R4/R5/R6/R7/R13; cts_ni held high with cts_en_i low (R8 ignore)
    for (int n = 0; n < NV; n++) begin
      v = VEC[n];
      do_reset();
      set_mode(v);
      cmd(0);
      chk(tx_rdy_o === 1 && tx_emt_o === 1, "R2 underrun after enable", {tx_rdy_o, tx_emt_o}, 3);
      wr_byte(v[7:0]);
      chk(tx_rdy_o === 0, "R2 rdy falls when held", tx_rdy_o, 0);
      tag = v[16] ? "R7 x1 frame" : (v[15:14] == 2'd0 ? "R6 5-bit stop" : "R5 stop length");
      run_frames(v, ~v[7:0], 1'b1, -1, {tag, " R3 R4 R8 R13"});
    end

    // R2 write while held is ignored
    v = {1'b0, 2'd3, 1'b0, 1'b0, 4'd0, 8'hA5};
    do_reset(); set_mode(v); cmd(0);
    wr_byte(8'hA5);
    wr_byte(8'h5A);
    run_frames(v, 8'h00, 1'b0, -1, "R2 extra write ignored");

    // R8 blocked start, R9 mid-frame change
    v = {1'b0, 2'd3, 1'b1, 1'b0, 4'd0, 8'h5A};
    do_reset(); set_mode(v); cts_en_i = 1'b1; cmd(0);
    wr_byte(8'h5A);
    bad = 0;
    for (int i = 0; i < 20; i++) begin
      do_tick(s);
      if (s !== 1'b1) bad++;
    end
    chk(bad == 0 && tx_rdy_o === 0, "R8 cts high holds mark", bad, 0);
    cts_ni = 1'b0;
    run_frames(v, 8'h00, 1'b0, 20, "R9 cts change mid-frame");

    // R10/R11 auto release
    for (int a = 1; a >= 0; a--) begin
      int f;
      logic e;
      v = {1'b0, 2'd3, 1'b0, 1'b0, 4'd0, 8'hC3};
      f = frame_t(v);
      do_reset(); set_mode(v); auto_rts_i = a[0];
      cmd(2); cmd(0);
      wr_byte(8'hC3);
      do_tick(s);
      bad = (s !== 1'b0) ? 1 : 0;
      wr_byte(8'h3C);
      cmd(1);
      chk(tx_rdy_o === 0, "R10 rdy low after disable", tx_rdy_o, 0);
      for (int i = 1; i < 2 * f + 21; i++) begin
        do_tick(s);
        e = exp_bit(v, 8'h3C, 1'b1, i);
        if (s !== e) bad++;
        if (a == 1 && i == 2 * f + 15) chk(rts_no === 1'b0, "R11 rts held through bit", rts_no, 0);
        if (a == 1 && i == 2 * f + 16) chk(rts_no === 1'b1, "R11 rts released", rts_no, 1);
      end
      chk(bad == 0, "R10 queued data still sent", bad, 0);
      chk(tx_rdy_o === 0 && tx_emt_o === 0, "R10 off after drain", {tx_rdy_o, tx_emt_o}, 0);
      if (a == 0) chk(rts_no === 1'b0, "R11 no auto release", rts_no, 0);
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule